// File: doc/BRIEF.md
# Memory Traffic Generator Engine

The engine creates synthetic memory traffic so that link throughput can be measured. Software programs a 64-bit start address, a data seed, a burst count and a control word through a 32-bit register port. A doorbell in the control word then starts a run. During the run the engine issues requests on a valid/ready master channel, either writes or reads, and each request carries a fixed number of 32-bit beats. The engine can step the address from one request to the next, or it can hold the address fixed. Write data can either stay constant or count up by one on every accepted beat.

A run ends after a programmed number of requests. With the repeat flag set, the run goes on until software clears the flag, and the request in flight then finishes before the engine stops. When a run ends, a done flag is raised in the status register. Two 64-bit byte counters, one for writes and one for reads, add up the completed traffic. Software can pause the counters, read both 32-bit halves while the value cannot change, and then resume counting.

Top module: `trafgen_top`

## Requirements
- R1: After reset, every register reads zero and req_valid is low.
- R2: These registers read back what was last written to them:
  - address low at 0x000 and address high at 0x004;
  - burst count at 0x008 and pattern at 0x010;
  - the two scratch words at 0x018 and 0x01C.

  The control register at 0x00C reads back with bit 0 as zero. The performance control register at 0x058 keeps only bit 5. Any other offset reads zero.
- R3: Writing control with bit 0 = 1 while the engine is idle starts a run.
  - Control bit 1 = 1 selects writes and 0 selects reads, and this is shown on req_write.
  - Control bits 13:2 give the request length in beats, shown on req_len.
  - Each request takes len accepted beats, and req_last is high on the final beat.
- R4: The first beat of a run carries the pattern register value (0x010) on req_data.
  - With control bit 16 set, the data rises by 1 on every accepted beat and keeps counting across requests.
  - With bit 16 clear, the data stays constant.
  - Read requests drive req_data to zero.
- R5: The first request of a run goes to {0x004, 0x000}. After each request the address advances by len*4 bytes. When control bit 18 is set, the address stays fixed.
- R6: With burst count bit 31 clear, bits 30:0 give the number of requests in the run. A count of zero raises done at once and issues no request.
- R7: While burst count bit 31 is set, the engine keeps issuing requests. Once bit 31 is cleared, the request in flight completes and no further request follows.
- R8: Status bit 0 (offset 0x014) goes high when a run ends. A status write with bit 0 = 0 clears it.
- R9: A doorbell written during a run is ignored: the direction, the length and the sequence of the run do not change.
- R10: The write byte counter (low word at 0x100, high word at 0x104) and the read byte counter (0x108 and 0x10C) each add len*4 when the last beat of a request of their direction is accepted, but only while performance control bit 5 is set. While bit 5 is clear, both counters hold their value.
- R11: While req_valid is high and req_ready is low, every request output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 9 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| req_valid | output | 1 | Request beat valid |
| req_ready | input | 1 | Request beat accepted by the target |
| req_write | output | 1 | 1 = write request, 0 = read request |
| req_addr | output | 64 | Request byte address |
| req_len | output | 12 | Request length in 32-bit beats |
| req_data | output | 32 | Beat data for writes, zero for reads |
| req_last | output | 1 | Final beat of the request |

## Verification
The assertions assume the following about the inputs:
- software programs a non-zero length before it rings the doorbell;
- reg_wr is a single-cycle strobe with a stable offset;
- req_ready can do anything, including staying low for several cycles.

The stimulus keeps every length non-zero. It writes one register per cycle and drives req_ready from a free-running pseudo-random sequence, with one deliberate long stall. This lets the hold and ignore properties see both accepted and stalled beats.

// File: rtl/trafgen_pkg.sv
package trafgen_pkg;
  localparam int REG_AW = 9;
  localparam int DW     = 32;
  localparam int AW     = 64;
  localparam int LEN_W  = 12;
  localparam int CNT_SW = 31;

  localparam logic [REG_AW-1:0] OFS_ADDR_LO = 9'h000;
  localparam logic [REG_AW-1:0] OFS_ADDR_HI = 9'h004;
  localparam logic [REG_AW-1:0] OFS_BURST   = 9'h008;
  localparam logic [REG_AW-1:0] OFS_CTRL    = 9'h00C;
  localparam logic [REG_AW-1:0] OFS_PAT     = 9'h010;
  localparam logic [REG_AW-1:0] OFS_STATUS  = 9'h014;
  localparam logic [REG_AW-1:0] OFS_SCR0    = 9'h018;
  localparam logic [REG_AW-1:0] OFS_SCR1    = 9'h01C;
  localparam logic [REG_AW-1:0] OFS_PERF    = 9'h058;
  localparam logic [REG_AW-1:0] OFS_WCNT_LO = 9'h100;
  localparam logic [REG_AW-1:0] OFS_WCNT_HI = 9'h104;
  localparam logic [REG_AW-1:0] OFS_RCNT_LO = 9'h108;
  localparam logic [REG_AW-1:0] OFS_RCNT_HI = 9'h10C;

  localparam int CTL_DB   = 0;
  localparam int CTL_WR   = 1;
  localparam int CTL_LEN  = 2;
  localparam int CTL_INC  = 16;
  localparam int CTL_FIX  = 18;
  localparam int BC_REP   = 31;
  localparam int PERF_EN  = 5;

  typedef struct packed {
    logic              wr;
    logic              inc;
    logic              fix;
    logic              rep;
    logic [LEN_W-1:0]  len;
    logic [CNT_SW-1:0] count;
    logic [AW-1:0]     addr;
    logic [DW-1:0]     pat;
  } launch_t;
endpackage

// File: rtl/trafgen_rst_sync.sv
module trafgen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign rst_no = sr_q[STAGES-1];
endmodule

// File: rtl/trafgen_regs.sv
module trafgen_regs
  import trafgen_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              busy,
  input  logic              done_set,
  input  logic [CNT_W-1:0]  cnt_w,
  input  logic [CNT_W-1:0]  cnt_r,
  output launch_t           launch,
  output logic              launch_go,
  output logic              repeat_live,
  output logic              perf_en,
  output logic              done
);
  localparam int CX = 2 * DW;

  logic [DW-1:0] alo_q, ahi_q, burst_q, ctl_q, pat_q, scr0_q, scr1_q;
  logic [DW-1:0] alo_d, ahi_d, burst_d, ctl_d, pat_d, scr0_d, scr1_d;
  logic          perf_q, perf_d, done_q, done_d;
  logic          wr_en;
  logic [CX-1:0] wx, rx;

  assign wx = CX'(cnt_w);
  assign rx = CX'(cnt_r);

  always_comb begin
    alo_d = alo_q; ahi_d = ahi_q; burst_d = burst_q; ctl_d = ctl_q;
    pat_d = pat_q; scr0_d = scr0_q; scr1_d = scr1_q; perf_d = perf_q;
    wr_en = 1'b0;
    if (reg_wr) begin
      wr_en = 1'b1;
      case (reg_addr)
        OFS_ADDR_LO: alo_d   = reg_wdata;
        OFS_ADDR_HI: ahi_d   = reg_wdata;
        OFS_BURST:   burst_d = reg_wdata;
        OFS_CTRL:    ctl_d   = {reg_wdata[DW-1:1], 1'b0};
        OFS_PAT:     pat_d   = reg_wdata;
        OFS_SCR0:    scr0_d  = reg_wdata;
        OFS_SCR1:    scr1_d  = reg_wdata;
        OFS_PERF:    perf_d  = reg_wdata[PERF_EN];
        default:     wr_en   = 1'b0;
      endcase
    end
  end

  always_comb begin
    done_d = done_q;
    if (done_set) done_d = 1'b1;
    else if (reg_wr && reg_addr == OFS_STATUS && !reg_wdata[0]) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alo_q <= '0; ahi_q <= '0; burst_q <= '0; ctl_q <= '0;
      pat_q <= '0; scr0_q <= '0; scr1_q <= '0; perf_q <= 1'b0;
    end else if (wr_en) begin
      alo_q <= alo_d; ahi_q <= ahi_d; burst_q <= burst_d; ctl_q <= ctl_d;
      pat_q <= pat_d; scr0_q <= scr0_d; scr1_q <= scr1_d; perf_q <= perf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign launch_go = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[CTL_DB] && !busy;

  always_comb begin
    launch.wr    = reg_wdata[CTL_WR];
    launch.inc   = reg_wdata[CTL_INC];
    launch.fix   = reg_wdata[CTL_FIX];
    launch.len   = reg_wdata[CTL_LEN +: LEN_W];
    launch.rep   = burst_q[BC_REP];
    launch.count = burst_q[CNT_SW-1:0];
    launch.addr  = {ahi_q, alo_q};
    launch.pat   = pat_q;
  end

  assign repeat_live = burst_q[BC_REP];
  assign perf_en     = perf_q;
  assign done        = done_q;

  always_comb begin
    case (reg_addr)
      OFS_ADDR_LO: reg_rdata = alo_q;
      OFS_ADDR_HI: reg_rdata = ahi_q;
      OFS_BURST:   reg_rdata = burst_q;
      OFS_CTRL:    reg_rdata = ctl_q;
      OFS_PAT:     reg_rdata = pat_q;
      OFS_STATUS:  reg_rdata = {{(DW-1){1'b0}}, done_q};
      OFS_SCR0:    reg_rdata = scr0_q;
      OFS_SCR1:    reg_rdata = scr1_q;
      OFS_PERF:    reg_rdata = DW'(perf_q) << PERF_EN;
      OFS_WCNT_LO: reg_rdata = wx[DW-1:0];
      OFS_WCNT_HI: reg_rdata = wx[CX-1:DW];
      OFS_RCNT_LO: reg_rdata = rx[DW-1:0];
      OFS_RCNT_HI: reg_rdata = rx[CX-1:DW];
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/trafgen_seq.sv
module trafgen_seq
  import trafgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_go,
  input  launch_t          launch,
  input  logic             repeat_live,
  input  logic             req_ready,
  output logic             req_valid,
  output logic             req_write,
  output logic [AW-1:0]    req_addr,
  output logic [LEN_W-1:0] req_len,
  output logic [DW-1:0]    req_data,
  output logic             req_last,
  output logic             cmpl,
  output logic             cmpl_wr,
  output logic [LEN_W+1:0] cmpl_bytes,
  output logic             done_set,
  output logic             busy
);
  logic              busy_q, busy_d;
  logic              wr_q, wr_d, inc_q, inc_d, fix_q, fix_d, rep_q, rep_d;
  logic [LEN_W-1:0]  len_q, len_d, beat_q, beat_d;
  logic [CNT_SW-1:0] rem_q, rem_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [DW-1:0]     data_q, data_d;
  logic              hs, last, stop;
  logic              ld_en;

  assign hs   = busy_q && req_ready;
  assign last = (beat_q == len_q - LEN_W'(1));
  assign stop = hs && last && !repeat_live && (rep_q || rem_q == CNT_SW'(1));

  always_comb begin
    busy_d = busy_q; wr_d = wr_q; inc_d = inc_q; fix_d = fix_q; rep_d = rep_q;
    len_d = len_q; beat_d = beat_q; rem_d = rem_q; addr_d = addr_q; data_d = data_q;
    done_set = 1'b0;
    ld_en    = 1'b0;
    if (!busy_q && launch_go) begin
      ld_en = 1'b1;
      if (launch.count == '0 && !launch.rep) begin
        done_set = 1'b1;
      end else begin
        busy_d = 1'b1;
        wr_d   = launch.wr;  inc_d = launch.inc; fix_d = launch.fix;
        rep_d  = launch.rep; len_d = launch.len; rem_d = launch.count;
        addr_d = launch.addr; data_d = launch.pat; beat_d = '0;
      end
    end else if (hs) begin
      ld_en = 1'b1;
      if (inc_q) data_d = data_q + DW'(1);
      if (last) begin
        beat_d = '0;
        if (!fix_q) addr_d = addr_q + AW'({len_q, 2'b00});
        if (!rep_q) rem_d = rem_q - CNT_SW'(1);
        if (stop) begin
          busy_d   = 1'b0;
          done_set = 1'b1;
        end
      end else begin
        beat_d = beat_q + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; wr_q <= 1'b0; inc_q <= 1'b0; fix_q <= 1'b0; rep_q <= 1'b0;
      len_q <= '0; beat_q <= '0; rem_q <= '0; addr_q <= '0; data_q <= '0;
    end else if (ld_en) begin
      busy_q <= busy_d; wr_q <= wr_d; inc_q <= inc_d; fix_q <= fix_d; rep_q <= rep_d;
      len_q <= len_d; beat_q <= beat_d; rem_q <= rem_d; addr_q <= addr_d; data_q <= data_d;
    end
  end

  assign req_valid  = busy_q;
  assign req_write  = wr_q;
  assign req_addr   = addr_q;
  assign req_len    = len_q;
  assign req_data   = wr_q ? data_q : '0;
  assign req_last   = busy_q && last;
  assign cmpl       = hs && last;
  assign cmpl_wr    = wr_q;
  assign cmpl_bytes = {len_q, 2'b00};
  assign busy       = busy_q;
endmodule

// File: rtl/trafgen_ctr.sv
module trafgen_ctr
  import trafgen_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cmpl,
  input  logic             cmpl_wr,
  input  logic [LEN_W+1:0] bytes,
  output logic [CNT_W-1:0] cnt_w,
  output logic [CNT_W-1:0] cnt_r
);
  localparam int NDIR = 2;

  logic [CNT_W-1:0] cnt_q [NDIR];

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    logic             hit;
    logic [CNT_W-1:0] cnt_d;
    assign hit = en && cmpl && (cmpl_wr == (g == 0));
    always_comb cnt_d = cnt_q[g] + CNT_W'(bytes);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q[g] <= '0;
      else if (hit) cnt_q[g] <= cnt_d;
    end
  end

  assign cnt_w = cnt_q[0];
  assign cnt_r = cnt_q[1];
endmodule

// File: rtl/trafgen_top.sv
module trafgen_top
  import trafgen_pkg::*;
#(
  parameter int CNT_W       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [AW-1:0]     req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [DW-1:0]     req_data,
  output logic              req_last
);
  logic             rst_n;
  launch_t          launch;
  logic             launch_go, repeat_live, perf_en, done_flag, done_set, busy;
  logic             cmpl, cmpl_wr;
  logic [LEN_W+1:0] cmpl_bytes;
  logic [CNT_W-1:0] cnt_w, cnt_r;

  trafgen_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_ni(rst_ni), .rst_no(rst_n)
  );

  trafgen_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .done_set(done_set), .cnt_w(cnt_w), .cnt_r(cnt_r), .launch(launch),
    .launch_go(launch_go), .repeat_live(repeat_live), .perf_en(perf_en),
    .done(done_flag)
  );

  trafgen_seq u_seq (
    .clk(clk), .rst_n(rst_n), .launch_go(launch_go), .launch(launch),
    .repeat_live(repeat_live), .req_ready(req_ready), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_data(req_data), .req_last(req_last), .cmpl(cmpl), .cmpl_wr(cmpl_wr),
    .cmpl_bytes(cmpl_bytes), .done_set(done_set), .busy(busy)
  );

  trafgen_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .en(perf_en), .cmpl(cmpl), .cmpl_wr(cmpl_wr),
    .bytes(cmpl_bytes), .cnt_w(cnt_w), .cnt_r(cnt_r)
  );
endmodule

// File: rtl/trafgen_chk.sv
module trafgen_chk
  import trafgen_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [AW-1:0]     req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic [DW-1:0]     req_data,
  input logic              req_last,
  input logic              perf_en,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [CNT_W-1:0]  cnt_r,
  input logic              done_flag,
  input logic              done_set
);
  // R11: stalled beat holds every request output
  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data)
      && $stable(req_last) && $stable(req_write) && $stable(req_len));

  // R3: address, direction and length stay put between beats of one request
  a_r3_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_last |=> req_valid && $stable(req_addr)
      && $stable(req_write) && $stable(req_len));

  // R9: a doorbell during a run leaves the run untouched
  a_r9_db_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !(req_ready && req_last) && reg_wr && reg_addr == OFS_CTRL
      && reg_wdata[CTL_DB] |=> req_valid && $stable(req_write) && $stable(req_len));

  // R10: paused counters keep their value
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !perf_en |=> $stable(cnt_w) && $stable(cnt_r));

  // R8: clearing status drops the done flag
  a_r8_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == OFS_STATUS && !reg_wdata[0] && !done_set |=> !done_flag);
endmodule

bind trafgen_top trafgen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
  .req_data(req_data), .req_last(req_last), .perf_en(perf_en),
  .cnt_w(cnt_w), .cnt_r(cnt_r), .done_flag(done_flag), .done_set(done_set)
);

// File: tb/sim_trafgen_top.sv
module sim_trafgen_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid, req_write, req_last;
  logic        req_ready = 1'b0;
  logic [63:0] req_addr;
  logic [11:0] req_len;
  logic [31:0] req_data;

  int checks = 0;
  int failures = 0;
  logic hold_rdy = 1'b0;
  logic [7:0] lf = 8'h5A;

  trafgen_top u0 (
    .clk(clk), .rst_ni(rst_ni), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_len(req_len), .req_data(req_data), .req_last(req_last)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    req_ready <= !hold_rdy && (lf[0] | lf[2]);
  end

  // behavioural reference model
  logic        m_busy, m_wr, m_inc, m_fix, m_rep, m_done, m_perf;
  logic [11:0] m_len, m_beat;
  logic [30:0] m_rem;
  logic [63:0] m_addr, m_wcnt, m_rcnt;
  logic [31:0] m_data, m_alo, m_ahi, m_burst, m_ctl, m_pat, m_s0, m_s1;

  function automatic logic [31:0] m_read(input logic [8:0] a);
    case (a)
      9'h000: return m_alo;
      9'h004: return m_ahi;
      9'h008: return m_burst;
      9'h00C: return m_ctl;
      9'h010: return m_pat;
      9'h014: return {31'd0, m_done};
      9'h018: return m_s0;
      9'h01C: return m_s1;
      9'h058: return m_perf ? 32'h20 : 32'h0;
      9'h100: return m_wcnt[31:0];
      9'h104: return m_wcnt[63:32];
      9'h108: return m_rcnt[31:0];
      9'h10C: return m_rcnt[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic busy_old, hs, last, dset, clr;
    if (!rst_ni) begin
      m_busy = 0; m_wr = 0; m_inc = 0; m_fix = 0; m_rep = 0; m_done = 0; m_perf = 0;
      m_len = 0; m_beat = 0; m_rem = 0; m_addr = 0; m_wcnt = 0; m_rcnt = 0;
      m_data = 0; m_alo = 0; m_ahi = 0; m_burst = 0; m_ctl = 0; m_pat = 0; m_s0 = 0; m_s1 = 0;
    end else begin
      busy_old = m_busy;
      hs = m_busy && req_ready;
      last = (m_beat == m_len - 12'd1);
      dset = 0; clr = 0;
      if (hs) begin
        if (m_inc) m_data = m_data + 1;
        if (last) begin
          if (m_perf) begin
            if (m_wr) m_wcnt = m_wcnt + 64'(m_len) * 4;
            else      m_rcnt = m_rcnt + 64'(m_len) * 4;
          end
          if (!m_fix) m_addr = m_addr + 64'(m_len) * 4;
          if (!m_burst[31] && (m_rep || m_rem == 1)) begin m_busy = 0; dset = 1; end
          if (!m_rep) m_rem = m_rem - 1;
          m_beat = 0;
        end else m_beat = m_beat + 1;
      end
      if (reg_wr) begin
        case (reg_addr)
          9'h000: m_alo = reg_wdata;
          9'h004: m_ahi = reg_wdata;
          9'h008: m_burst = reg_wdata;
          9'h010: m_pat = reg_wdata;
          9'h018: m_s0 = reg_wdata;
          9'h01C: m_s1 = reg_wdata;
          9'h058: m_perf = reg_wdata[5];
          9'h014: if (!reg_wdata[0]) clr = 1;
          9'h00C: begin
            m_ctl = reg_wdata & 32'hFFFF_FFFE;
            if (reg_wdata[0] && !busy_old) begin
              if (m_burst[30:0] == 0 && !m_burst[31]) dset = 1;
              else begin
                m_busy = 1; m_wr = reg_wdata[1]; m_len = reg_wdata[13:2];
                m_inc = reg_wdata[16]; m_fix = reg_wdata[18]; m_rep = m_burst[31];
                m_rem = m_burst[30:0]; m_addr = {m_ahi, m_alo}; m_data = m_pat; m_beat = 0;
              end
            end
          end
          default: ;
        endcase
      end
      if (dset) m_done = 1; else if (clr) m_done = 0;
    end
    #5;
    check("R3 req_valid", 64'(req_valid), 64'(m_busy));
    if (m_busy) begin
      check("R3 req_write", 64'(req_write), 64'(m_wr));
      check("R3 req_len", 64'(req_len), 64'(m_len));
      check("R3 req_last", 64'(req_last), 64'(m_beat == m_len - 12'd1));
      check("R5 req_addr", req_addr, m_addr);
      check("R4 req_data", 64'(req_data), m_wr ? 64'(m_data) : 64'd0);
    end
    if (reg_addr >= 9'h100) check("R10 rdata", 64'(reg_rdata), 64'(m_read(reg_addr)));
    else if (reg_addr == 9'h014) check("R8 rdata", 64'(reg_rdata), 64'(m_read(reg_addr)));
    else check("R2 rdata", 64'(reg_rdata), 64'(m_read(reg_addr)));
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #5 d = reg_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [8:0] a, input logic [31:0] e);
    logic [31:0] v;
    rd(a, v);
    check(tag, 64'(v), 64'(e));
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] v;
    v = 0;
    for (int i = 0; i < 3000 && !v[0]; i++) rd(9'h014, v);
    check(tag, 64'(v[0]), 64'd1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(20 * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] a0, a1;
    logic [63:0] sa, sd;
    idle(3);
    rst_ni = 1'b1;
    idle(6);
    // R1 reset state
    rdchk("R1 addr_lo", 9'h000, 0);
    rdchk("R1 burst", 9'h008, 0);
    rdchk("R1 ctrl", 9'h00C, 0);
    rdchk("R1 status", 9'h014, 0);
    rdchk("R1 perf", 9'h058, 0);
    rdchk("R1 wcnt_hi", 9'h104, 0);
    check("R1 req_valid", 64'(req_valid), 0);
    // R2 register storage
    wr(9'h000, 32'h0000_0100);
    wr(9'h004, 32'h0000_0001);
    wr(9'h010, 32'h0000_0010);
    wr(9'h018, 32'hA5A5_0001);
    wr(9'h01C, 32'h1234_5678);
    wr(9'h058, 32'hFFFF_FFFF);
    rdchk("R2 addr_lo", 9'h000, 32'h0000_0100);
    rdchk("R2 addr_hi", 9'h004, 32'h0000_0001);
    rdchk("R2 pattern", 9'h010, 32'h10);
    rdchk("R2 scratch0", 9'h018, 32'hA5A5_0001);
    rdchk("R2 scratch1", 9'h01C, 32'h1234_5678);
    rdchk("R2 perf bit5 only", 9'h058, 32'h20);
    rdchk("R2 reserved 0x020", 9'h020, 0);
    rdchk("R2 reserved 0x05C", 9'h05C, 0);
    rdchk("R2 reserved 0x110", 9'h110, 0);
    // R3 R4 R5 R6: write run, 3 requests of 4 beats, incrementing data
    wr(9'h008, 32'd3);
    wr(9'h00C, 32'h0001_0013);
    wait_done("R6 done after three requests");
    rdchk("R10 write bytes", 9'h100, 32'd48);
    rdchk("R10 write bytes hi", 9'h104, 0);
    rdchk("R3 doorbell reads zero", 9'h00C, 32'h0001_0012);
    wr(9'h014, 32'h0);
    rdchk("R8 done cleared", 9'h014, 0);
    // R5 fixed-address read run, 2 requests of 3 beats
    wr(9'h008, 32'd2);
    wr(9'h00C, 32'h0004_000D);
    wait_done("R8 done after read run");
    rdchk("R10 read bytes", 9'h108, 32'd24);
    rdchk("R10 write bytes unchanged", 9'h100, 32'd48);
    // R6 zero count
    wr(9'h014, 32'h0);
    wr(9'h008, 32'd0);
    wr(9'h00C, 32'h0000_0003);
    check("R6 no request for zero count", 64'(req_valid), 0);
    rdchk("R6 done for zero count", 9'h014, 1);
    // R7 repeat run
    wr(9'h014, 32'h0);
    wr(9'h008, 32'h8000_0000);
    wr(9'h00C, 32'h0001_000B);
    idle(40);
    check("R7 repeat still running", 64'(req_valid), 1);
    // R9 doorbell during run
    wr(9'h00C, 32'h0000_0005);
    idle(1);
    #5;
    check("R9 direction kept", 64'(req_write), 1);
    check("R9 length kept", 64'(req_len), 2);
    // R10 pause counters
    wr(9'h058, 32'h0);
    rd(9'h100, a0);
    idle(20);
    rd(9'h100, a1);
    check("R10 paused counter", 64'(a1), 64'(a0));
    wr(9'h058, 32'h20);
    // R11 stall hold
    @(negedge clk);
    hold_rdy = 1'b1;
    idle(2);
    #5 sa = req_addr; sd = 64'(req_data);
    idle(4);
    #5;
    check("R11 addr held", req_addr, sa);
    check("R11 data held", 64'(req_data), sd);
    check("R11 valid held", 64'(req_valid), 1);
    @(negedge clk);
    hold_rdy = 1'b0;
    // R7 stop by clearing repeat
    wr(9'h008, 32'h0);
    wait_done("R7 done after repeat cleared");
    check("R7 stopped", 64'(req_valid), 0);
    idle(10);
    check("R7 stays stopped", 64'(req_valid), 0);
    rdchk("R10 final write bytes", 9'h100, m_wcnt[31:0]);
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule